// File: doc/BRIEF.md
# Privilege Trap and Return Sequencer

This block keeps the hart's current privilege level together with the status bits that a trap stacks and a return unstacks. It also keeps the cause, trap-value and exception-PC registers for the machine and supervisor levels. The pipeline's commit stage drives one command per cycle on a two-bit opcode: trap, machine return or supervisor return. A trap command also carries its target level, an interrupt flag, a cause code, the faulting PC and an optional trap value.

All state sits in flip-flops and updates on the clock edge that accepts the command. On that same edge a one-cycle redirect pulse is registered. The pulse comes with a select that tells fetch which source gives the next PC: the machine trap vector, the supervisor trap vector, the saved machine exception PC, or the saved supervisor exception PC. A trap command that asks for an impossible level change leaves the state untouched and raises a one-cycle error pulse instead. The translation-override bit (MPRV) can be loaded from outside on cycles that carry no command, so that a return can clear it.

Top module: `pts_sequencer`

## Requirements
- R1: While synchronous reset is high, and after it is released, the state is as follows. Privilege is machine (encoding 2'b11; supervisor is 2'b01, user is 2'b00). MIE, MPIE, SIE, SPIE, SPP and MPRV are 0. All cause, trap-value and exception-PC registers are 0. MPP holds user when user mode exists and machine otherwise. No pulse is active.
- R2: An accepted machine trap (opcode 2'b01, target 2'b11) has these effects on the next edge. The machine cause register gets the interrupt flag in bit XLEN-1 and the zero-extended code in its low bits. The exception PC gets the command PC. MPIE takes the old MIE, MIE clears, MPP takes the old privilege, and privilege becomes machine.
- R3: An accepted supervisor trap (target 2'b01, from user or supervisor) has the same effect on the supervisor cause, trap-value and exception-PC registers, and SPIE takes SIE, SIE clears and privilege becomes supervisor. SPP becomes 0 for a trap from user and 1 for a trap from supervisor.
- R4: The trap-value register of the target level takes the supplied value when the has-value flag is set and 0 when it is clear.
- R5: A trap that targets user, targets the reserved encoding 2'b10, or targets supervisor while in machine mode is ignored. No register changes and no redirect is issued. The error output is high for exactly the following cycle.
- R6: A machine return (opcode 2'b10) copies MPIE into MIE, sets MPIE to 1 and moves to the privilege held in MPP.
- R7: After a machine return, MPP holds user when user mode exists (HAS_USER=1) and machine otherwise.
- R8: A supervisor return (opcode 2'b11) copies SPIE into SIE, sets SPIE to 1, moves to supervisor when SPP is 1 and to user when it is 0, then clears SPP.
- R9: After either return, MPRV is 0 when the new privilege is not machine. When a machine return lands in machine mode, MPRV keeps its value.
- R10: The MPRV load input takes effect only on a cycle whose opcode is 2'b00. Together with any command it is ignored.
- R11: Every accepted command raises the redirect output for exactly one cycle, on the edge that updates the state. The select is 0 for a machine trap, 1 for a supervisor trap, 2 for a machine return and 3 for a supervisor return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | 0 none, 1 trap, 2 machine return, 3 supervisor return |
| trap_target | input | 2 | Target privilege of a trap |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CAUSE_W | Cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_has_val | input | 1 | Trap value supplied |
| trap_val | input | XLEN | Trap value |
| mprv_load | input | 1 | Load MPRV when no command is present |
| mprv_in | input | 1 | Value for MPRV |
| priv | output | 2 | Current privilege |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine previous interrupt enable |
| m_pp | output | 2 | Machine previous privilege |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor previous interrupt enable |
| s_pp | output | 1 | Supervisor previous privilege |
| mprv | output | 1 | Translation-override bit |
| m_cause | output | XLEN | Machine cause |
| m_tval | output | XLEN | Machine trap value |
| m_epc | output | XLEN | Machine exception PC |
| s_cause | output | XLEN | Supervisor cause |
| s_tval | output | XLEN | Supervisor trap value |
| s_epc | output | XLEN | Supervisor exception PC |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_sel | output | 2 | Next-PC source select |
| trap_err | output | 1 | One-cycle illegal-trap pulse |

## Verification
The bench builds two copies of the block from one shared stimulus: u_dut with the defaults (XLEN=32, CAUSE_W=6, HAS_USER=1), and a second copy with HAS_USER=0. The second copy is compared only in the scenario where a machine return from reset must leave MPP at machine instead of user. That makes both outcomes of R7 and both reset values of MPP reachable. Running at XLEN=32 puts the interrupt flag in bit 31, so the zero padding between that flag and the 6-bit code is visible in the cause registers.

// File: rtl/pts_pkg.sv
package pts_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TRAP = 2'd1,
    OP_MRET = 2'd2,
    OP_SRET = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_MVEC = 2'd0,
    SEL_SVEC = 2'd1,
    SEL_MEPC = 2'd2,
    SEL_SEPC = 2'd3
  } sel_e;
endpackage

// File: rtl/pts_cmd_check.sv
module pts_cmd_check
  import pts_pkg::*;
(
  input  logic [1:0] op,
  input  logic [1:0] target,
  input  logic [1:0] cur_priv,
  output logic       do_mtrap,
  output logic       do_strap,
  output logic       do_mret,
  output logic       do_sret,
  output logic       bad_trap
);
  logic is_trap;

  always_comb begin
    is_trap  = (op == OP_TRAP);
    do_mtrap = is_trap && (target == PRIV_M);
    do_strap = is_trap && (target == PRIV_S) && (cur_priv != PRIV_M);
    bad_trap = is_trap && !do_mtrap && !do_strap;
    do_mret  = (op == OP_MRET);
    do_sret  = (op == OP_SRET);
  end
endmodule

// File: rtl/pts_trap_regs.sv
module pts_trap_regs #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               is_irq,
  input  logic [CAUSE_W-1:0] code,
  input  logic [XLEN-1:0]    pc,
  input  logic               has_val,
  input  logic [XLEN-1:0]    val,
  output logic [XLEN-1:0]    cause_q,
  output logic [XLEN-1:0]    tval_q,
  output logic [XLEN-1:0]    epc_q
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  initial begin
    if (PAD_W < 1) $error("CAUSE_W must leave room for the interrupt bit");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      tval_q  <= '0;
      epc_q   <= '0;
    end else if (load) begin
      cause_q <= {is_irq, {PAD_W{1'b0}}, code};
      tval_q  <= has_val ? val : '0;
      epc_q   <= pc;
    end
  end

  // R2
  epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> epc_q == $past(pc));

  // R4
  tval_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !has_val) |=> tval_q == '0);

  // R2
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cause_q));
endmodule

// File: rtl/pts_status.sv
module pts_status
  import pts_pkg::*;
#(
  parameter bit HAS_USER = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       do_mtrap,
  input  logic       do_strap,
  input  logic       do_mret,
  input  logic       do_sret,
  input  logic       mprv_load,
  input  logic       mprv_in,
  input  logic       cmd_present,
  output logic [1:0] priv_q,
  output logic       mie_q,
  output logic       mpie_q,
  output logic [1:0] mpp_q,
  output logic       sie_q,
  output logic       spie_q,
  output logic       spp_q,
  output logic       mprv_q
);
  localparam logic [1:0] LOW_PRIV = HAS_USER ? PRIV_U : PRIV_M;

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q <= PRIV_M;
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      mpp_q  <= LOW_PRIV;
      sie_q  <= 1'b0;
      spie_q <= 1'b0;
      spp_q  <= 1'b0;
      mprv_q <= 1'b0;
    end else if (do_mtrap) begin
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
      mpp_q  <= priv_q;
      priv_q <= PRIV_M;
    end else if (do_strap) begin
      spie_q <= sie_q;
      sie_q  <= 1'b0;
      spp_q  <= (priv_q == PRIV_S);
      priv_q <= PRIV_S;
    end else if (do_mret) begin
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      priv_q <= mpp_q;
      mpp_q  <= LOW_PRIV;
      if (mpp_q != PRIV_M) mprv_q <= 1'b0;
    end else if (do_sret) begin
      sie_q  <= spie_q;
      spie_q <= 1'b1;
      priv_q <= spp_q ? PRIV_S : PRIV_U;
      spp_q  <= 1'b0;
      mprv_q <= 1'b0;
    end else if (mprv_load && !cmd_present) begin
      mprv_q <= mprv_in;
    end
  end

  // R2
  mtrap_stack_chk: assert property (@(posedge clk) disable iff (rst)
    do_mtrap |=> (!mie_q && mpie_q == $past(mie_q) && mpp_q == $past(priv_q)));

  // R3
  strap_spp_chk: assert property (@(posedge clk) disable iff (rst)
    do_strap |=> (priv_q == PRIV_S && spp_q == ($past(priv_q) == PRIV_S)));

  // R6
  mret_pie_chk: assert property (@(posedge clk) disable iff (rst)
    do_mret |=> (mpie_q && mie_q == $past(mpie_q)));

  // R8
  sret_spp_chk: assert property (@(posedge clk) disable iff (rst)
    do_sret |=> (!spp_q && spie_q && priv_q != PRIV_M));

  // R9
  ret_mprv_chk: assert property (@(posedge clk) disable iff (rst)
    (do_mret || do_sret) |=> (priv_q == PRIV_M || !mprv_q));

  // R10
  mprv_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_present && !do_mret && !do_sret) |=> $stable(mprv_q));
endmodule

// File: rtl/pts_sequencer.sv
module pts_sequencer
  import pts_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 6,
  parameter bit HAS_USER = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmd_op,
  input  logic [1:0]         trap_target,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_code,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               trap_has_val,
  input  logic [XLEN-1:0]    trap_val,
  input  logic               mprv_load,
  input  logic               mprv_in,
  output logic [1:0]         priv,
  output logic               m_ie,
  output logic               m_pie,
  output logic [1:0]         m_pp,
  output logic               s_ie,
  output logic               s_pie,
  output logic               s_pp,
  output logic               mprv,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_tval,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_tval,
  output logic [XLEN-1:0]    s_epc,
  output logic               redirect_valid,
  output logic [1:0]         redirect_sel,
  output logic               trap_err
);
  logic do_mtrap, do_strap, do_mret, do_sret, bad_trap;
  logic cmd_present;

  assign cmd_present = (cmd_op != OP_NONE);

  pts_cmd_check u_check (
    .op       (cmd_op),
    .target   (trap_target),
    .cur_priv (priv),
    .do_mtrap (do_mtrap),
    .do_strap (do_strap),
    .do_mret  (do_mret),
    .do_sret  (do_sret),
    .bad_trap (bad_trap)
  );

  pts_status #(.HAS_USER(HAS_USER)) u_status (
    .clk         (clk),
    .rst         (rst),
    .do_mtrap    (do_mtrap),
    .do_strap    (do_strap),
    .do_mret     (do_mret),
    .do_sret     (do_sret),
    .mprv_load   (mprv_load),
    .mprv_in     (mprv_in),
    .cmd_present (cmd_present),
    .priv_q      (priv),
    .mie_q       (m_ie),
    .mpie_q      (m_pie),
    .mpp_q       (m_pp),
    .sie_q       (s_ie),
    .spie_q      (s_pie),
    .spp_q       (s_pp),
    .mprv_q      (mprv)
  );

  pts_trap_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_mregs (
    .clk (clk), .rst (rst), .load (do_mtrap), .is_irq (trap_irq),
    .code (trap_code), .pc (trap_pc), .has_val (trap_has_val), .val (trap_val),
    .cause_q (m_cause), .tval_q (m_tval), .epc_q (m_epc)
  );

  pts_trap_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_sregs (
    .clk (clk), .rst (rst), .load (do_strap), .is_irq (trap_irq),
    .code (trap_code), .pc (trap_pc), .has_val (trap_has_val), .val (trap_val),
    .cause_q (s_cause), .tval_q (s_tval), .epc_q (s_epc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_sel   <= SEL_MVEC;
      trap_err       <= 1'b0;
    end else begin
      redirect_valid <= do_mtrap || do_strap || do_mret || do_sret;
      trap_err       <= bad_trap;
      if (do_mtrap)      redirect_sel <= SEL_MVEC;
      else if (do_strap) redirect_sel <= SEL_SVEC;
      else if (do_mret)  redirect_sel <= SEL_MEPC;
      else if (do_sret)  redirect_sel <= SEL_SEPC;
    end
  end

  // R5
  err_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    trap_err |-> (priv == $past(priv) && m_epc == $past(m_epc) && s_epc == $past(s_epc)));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redirect_valid, trap_err}));

  // R11
  redirect_once_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_present |=> !redirect_valid);
endmodule

// File: tb/pts_sequencer_tb.sv
`timescale 1ns/1ps
module pts_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd_op = 2'd0, trap_target = 2'd0;
  logic        trap_irq = 1'b0, trap_has_val = 1'b0, mprv_load = 1'b0, mprv_in = 1'b0;
  logic [5:0]  trap_code = '0;
  logic [31:0] trap_pc = '0, trap_val = '0;

  logic [1:0]  priv, m_pp, redirect_sel;
  logic        m_ie, m_pie, s_ie, s_pie, s_pp, mprv, redirect_valid, trap_err;
  logic [31:0] m_cause, m_tval, m_epc, s_cause, s_tval, s_epc;

  logic [1:0]  nu_priv, nu_m_pp, nu_sel;
  logic        nu_m_ie, nu_m_pie, nu_s_ie, nu_s_pie, nu_s_pp, nu_mprv, nu_rv, nu_err;
  logic [31:0] nu_mc, nu_mt, nu_me, nu_sc, nu_st, nu_se;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pts_sequencer u_dut (
    .clk, .rst, .cmd_op, .trap_target, .trap_irq, .trap_code, .trap_pc,
    .trap_has_val, .trap_val, .mprv_load, .mprv_in,
    .priv, .m_ie, .m_pie, .m_pp, .s_ie, .s_pie, .s_pp, .mprv,
    .m_cause, .m_tval, .m_epc, .s_cause, .s_tval, .s_epc,
    .redirect_valid, .redirect_sel, .trap_err
  );

  pts_sequencer #(.HAS_USER(1'b0)) u_dut_nu (
    .clk, .rst, .cmd_op, .trap_target, .trap_irq, .trap_code, .trap_pc,
    .trap_has_val, .trap_val, .mprv_load, .mprv_in,
    .priv(nu_priv), .m_ie(nu_m_ie), .m_pie(nu_m_pie), .m_pp(nu_m_pp),
    .s_ie(nu_s_ie), .s_pie(nu_s_pie), .s_pp(nu_s_pp), .mprv(nu_mprv),
    .m_cause(nu_mc), .m_tval(nu_mt), .m_epc(nu_me),
    .s_cause(nu_sc), .s_tval(nu_st), .s_epc(nu_se),
    .redirect_valid(nu_rv), .redirect_sel(nu_sel), .trap_err(nu_err)
  );

  // scoreboard model
  logic [1:0]  e_priv, e_mpp, e_sel;
  logic        e_mie, e_mpie, e_sie, e_spie, e_spp, e_mprv, e_rv, e_err;
  logic [31:0] e_mc, e_mt, e_me, e_sc, e_st, e_se;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "priv", priv, e_priv);      chk(req, "m_ie", m_ie, e_mie);
    chk(req, "m_pie", m_pie, e_mpie);    chk(req, "m_pp", m_pp, e_mpp);
    chk(req, "s_ie", s_ie, e_sie);       chk(req, "s_pie", s_pie, e_spie);
    chk(req, "s_pp", s_pp, e_spp);       chk(req, "mprv", mprv, e_mprv);
    chk(req, "m_cause", m_cause, e_mc);  chk(req, "m_tval", m_tval, e_mt);
    chk(req, "m_epc", m_epc, e_me);      chk(req, "s_cause", s_cause, e_sc);
    chk(req, "s_tval", s_tval, e_st);    chk(req, "s_epc", s_epc, e_se);
    chk(req, "redirect_valid", redirect_valid, e_rv);
    chk(req, "trap_err", trap_err, e_err);
    if (e_rv) chk(req, "redirect_sel", redirect_sel, e_sel);
  endtask

  task automatic model(input logic [1:0] op, input logic [1:0] tgt, input logic irq,
                       input logic [5:0] code, input logic [31:0] pc, input logic hv,
                       input logic [31:0] v, input logic ml, input logic mi);
    e_rv = 1'b0; e_err = 1'b0;
    if (op == 2'd1) begin
      if (tgt == 2'b11) begin
        e_mc = {irq, 25'd0, code}; e_mt = hv ? v : 32'd0; e_me = pc;
        e_mpie = e_mie; e_mie = 1'b0; e_mpp = e_priv; e_priv = 2'b11;
        e_rv = 1'b1; e_sel = 2'd0;
      end else if (tgt == 2'b01 && e_priv != 2'b11) begin
        e_sc = {irq, 25'd0, code}; e_st = hv ? v : 32'd0; e_se = pc;
        e_spie = e_sie; e_sie = 1'b0; e_spp = (e_priv == 2'b01); e_priv = 2'b01;
        e_rv = 1'b1; e_sel = 2'd1;
      end else begin
        e_err = 1'b1;
      end
    end else if (op == 2'd2) begin
      e_mie = e_mpie; e_mpie = 1'b1; e_priv = e_mpp; e_mpp = 2'b00;
      if (e_priv != 2'b11) e_mprv = 1'b0;
      e_rv = 1'b1; e_sel = 2'd2;
    end else if (op == 2'd3) begin
      e_sie = e_spie; e_spie = 1'b1; e_priv = e_spp ? 2'b01 : 2'b00; e_spp = 1'b0;
      e_mprv = 1'b0;
      e_rv = 1'b1; e_sel = 2'd3;
    end else if (ml) begin
      e_mprv = mi;
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [1:0] tgt, input logic irq,
                      input logic [5:0] code, input logic [31:0] pc, input logic hv,
                      input logic [31:0] v, input logic ml, input logic mi, input string req);
    @(negedge clk);
    cmd_op = op; trap_target = tgt; trap_irq = irq; trap_code = code; trap_pc = pc;
    trap_has_val = hv; trap_val = v; mprv_load = ml; mprv_in = mi;
    model(op, tgt, irq, code, pc, hv, v, ml, mi);
    @(posedge clk);
    @(negedge clk);
    cmd_op = 2'd0; mprv_load = 1'b0; trap_has_val = 1'b0;
    compare(req);
  endtask

  task automatic idle(input string req);
    step(2'd0, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_priv = 2'b11; e_mie = 0; e_mpie = 0; e_mpp = 2'b00; e_sie = 0; e_spie = 0;
    e_spp = 0; e_mprv = 0; e_mc = 0; e_mt = 0; e_me = 0; e_sc = 0; e_st = 0; e_se = 0;
    e_rv = 0; e_err = 0; e_sel = 0;
    compare("R1");
    chk("R1", "nouser m_pp", nu_m_pp, 2'b11);
  endtask

  task automatic t_nouser_mret();
    step(2'd2, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, "R7");
    chk("R7", "nouser priv", nu_priv, 2'b11);
    chk("R7", "nouser m_pp", nu_m_pp, 2'b11);
    chk("R6", "nouser m_pie", nu_m_pie, 1'b1);
    chk("R11", "nouser sel", nu_sel, 2'd2);
  endtask

  task automatic t_nested();
    step(2'd1, 2'b01, 1'b0, 6'd8, 32'h0000_1000, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0, "R3 R4");
    step(2'd1, 2'b01, 1'b1, 6'd5, 32'h0000_2004, 1'b1, 32'hCAFE_0001, 1'b0, 1'b0, "R3 R4");
    step(2'd1, 2'b11, 1'b1, 6'd11, 32'h0000_3008, 1'b1, 32'h1234_5678, 1'b0, 1'b0, "R2 R4");
    idle("R11");
    step(2'd2, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, "R6 R7");
    step(2'd3, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, "R8");
    step(2'd3, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, "R8");
    step(2'd1, 2'b11, 1'b0, 6'd63, 32'h0000_4000, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_illegal();
    step(2'd1, 2'b01, 1'b0, 6'd2, 32'h0000_5000, 1'b1, 32'h55, 1'b0, 1'b0, "R5");
    idle("R5");
    step(2'd1, 2'b00, 1'b0, 6'd3, 32'h0000_6000, 1'b1, 32'h66, 1'b0, 1'b0, "R5");
    step(2'd1, 2'b10, 1'b1, 6'd4, 32'h0000_7000, 1'b1, 32'h77, 1'b0, 1'b0, "R5");
    idle("R5");
  endtask

  task automatic t_mprv();
    step(2'd0, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, "R10");
    step(2'd1, 2'b11, 1'b0, 6'd9, 32'h0000_8000, 1'b0, 32'd0, 1'b1, 1'b0, "R10");
    step(2'd2, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, "R9");
    step(2'd2, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, "R9");
    step(2'd0, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, "R10");
    step(2'd1, 2'b01, 1'b0, 6'd1, 32'h0000_9000, 1'b0, 32'd0, 1'b0, 1'b0, "R3");
    step(2'd3, 2'd0, 1'b0, 6'd0, 32'd0, 1'b0, 32'd0, 1'b1, 1'b1, "R9 R10");
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_nouser_mret();
    t_nested();
    t_illegal();
    t_mprv();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule